// File: doc/BRIEF.md
# Hypercube Dimension-Ordered Wormhole Router Node

This block is a single switching node of a binary hypercube network with `DIM` dimensions. The node has its own fixed `DIM`-bit label, given as a parameter. It has `DIM + 1` input ports and `DIM + 1` output ports. Port k for k < `DIM` is the link to the neighbour whose label differs from the node's label only in bit k. Port `DIM` is the local port: its input injects traffic from the attached processor, and its output delivers traffic to that processor. Every port carries one flit per cycle under a valid/ready handshake. Each flit has a 2-bit kind field and a `DW`-bit payload.

For a message-opening flit, the node XORs its own label with the destination label held in the low `DIM` payload bits. The flit leaves on the dimension of the lowest set bit of that XOR. If the XOR is zero, the flit goes to the local output. The path has no storage, so a flit appears at its output in the same cycle that it is offered. The opening flit claims the output for its input port, and the closing flit frees it. Each node repeats this decision, so a message crosses one link for each differing label bit, which is at most `DIM` links. For example, with `DIM` = 3 a message from 010 to 111 goes through 011.

Top module: `hcube_router`

## Requirements
- R1: While reset is held and no input is valid, every `out_valid` and `in_ready` bit is 0, and no output is claimed after reset.
- R2: An opening flit whose destination bits (payload bits `DIM`-1:0) equal the node label is presented on output port `DIM`.
- R3: An opening flit whose destination differs from the node label is presented on link output k, where k is the lowest bit position at which the two labels differ.
- R4: Forwarding has no storage. A flit offered on an input appears on its output in the same cycle, and `in_ready` follows that output's `out_ready` in the same cycle.
- R5: Kind encoding: 2'b01 opens a message, 2'b00 is a middle flit, 2'b10 closes a message, and 2'b11 is a single-flit message. A transferred 2'b01 claims the output for its input. Middle and closing flits from that input then use the same output. A transferred 2'b10 frees the output, and 2'b11 never claims it.
- R6: While an output is claimed, opening flits from other inputs that route to it are not presented, and those inputs see `in_ready` low.
- R7: When several inputs offer opening flits to the same unclaimed output in one cycle, the lowest-numbered input is presented and the others see `in_ready` low.
- R8: A flit moves only when valid and ready are both high. When `out_ready` is low, the flit stays on its input and the claim state does not change.
- R9: The kind field and the full payload of each flit reach the output unchanged.
- R10: Different outputs serve different inputs in the same cycle, independently, and each input is served by at most one output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | DIM+1 | Flit offered on each input port |
| in_ready | output | DIM+1 | Flit accepted on each input port |
| in_kind | input | 2*(DIM+1) | Kind field of each input flit, 2 bits per port |
| in_data | input | DW*(DIM+1) | Payload of each input flit, DW bits per port |
| out_valid | output | DIM+1 | Flit presented on each output port |
| out_ready | input | DIM+1 | Downstream accepts the flit on each output port |
| out_kind | output | 2*(DIM+1) | Kind field of each output flit |
| out_data | output | DW*(DIM+1) | Payload of each output flit |

## Verification
The only internal state is the claim flag and the owner of each output. If that state is wrong, the effect reaches the ports in the same cycle that the affected output is next contended or next carries a middle flit. A stuck claim keeps `in_ready` low for a waiting opening flit. A lost claim leaves a middle flit unpresented. A wrong owner sends another input's flit out. The reference model tracks its own claim table and compares every output and ready bit on every clock, so each of these faults shows up in the first cycle it becomes visible.

// File: rtl/hcr_pkg.sv
package hcr_pkg;
   // bit 0 set: flit opens a path; bit 1 set: flit closes a path
   typedef enum logic [1:0] {
      FK_MID   = 2'b00,
      FK_OPEN  = 2'b01,
      FK_CLOSE = 2'b10,
      FK_SOLO  = 2'b11
   } flit_kind_e;

   function automatic logic kind_opens(input logic [1:0] k);
      return k[0];
   endfunction

   function automatic logic kind_closes(input logic [1:0] k);
      return k[1];
   endfunction
endpackage

// File: rtl/hcr_route.sv
module hcr_route #(
   parameter int DIM = 3,
   parameter logic [DIM-1:0] NODE_ID = 3'b010,
   localparam int PW = $clog2(DIM + 1)
) (
   input  logic [DIM-1:0] dest,
   output logic [PW-1:0]  port
);
   logic [DIM-1:0] diff;

   assign diff = dest ^ NODE_ID;

   // lowest differing bit wins; no difference selects the local port
   always_comb begin
      port = PW'(DIM);
      for (int k = DIM - 1; k >= 0; k--) begin
         if (diff[k]) port = PW'(k);
      end
   end
endmodule

// File: rtl/hcr_outsel.sv
module hcr_outsel #(
   parameter int NP = 4,
   localparam int IW = $clog2(NP)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [NP-1:0] req,
   input  logic          xfer,
   input  logic          opens,
   input  logic          closes,
   output logic          sel_ok,
   output logic [IW-1:0] sel_idx
);
   logic          locked;
   logic [IW-1:0] owner;

   always_comb begin
      sel_ok  = locked;
      sel_idx = owner;
      if (!locked) begin
         for (int i = NP - 1; i >= 0; i--) begin
            if (req[i]) begin
               sel_ok  = 1'b1;
               sel_idx = IW'(i);
            end
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         locked <= 1'b0;
         owner  <= '0;
      end else if (xfer) begin
         if (closes) begin
            locked <= 1'b0;
         end else if (opens) begin
            locked <= 1'b1;
            owner  <= sel_idx;
         end
      end
   end

   // R5: a claim persists with the same owner until a closing flit moves
   p_claim_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (locked && !(xfer && closes)) |=> (locked && $stable(owner)));

   // R5: a moved closing flit frees the output
   p_claim_free_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (xfer && closes) |=> !locked);

   // R8: without a transfer the claim state is unchanged
   p_idle_keep_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !xfer |=> $stable(locked));
endmodule

// File: rtl/hcube_router.sv
module hcube_router #(
   parameter int DIM = 3,
   parameter logic [DIM-1:0] NODE_ID = 3'b010,
   parameter int DW = 16,
   localparam int NP = DIM + 1,
   localparam int IW = $clog2(NP)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [NP-1:0]     in_valid,
   output logic [NP-1:0]     in_ready,
   input  logic [2*NP-1:0]   in_kind,
   input  logic [DW*NP-1:0]  in_data,
   output logic [NP-1:0]     out_valid,
   input  logic [NP-1:0]     out_ready,
   output logic [2*NP-1:0]   out_kind,
   output logic [DW*NP-1:0]  out_data
);
   import hcr_pkg::*;

   if (DIM < 1 || DIM > 16) begin : g_bad_dim
      $error("hcube_router: DIM must lie in 1..16");
   end
   if (DW < DIM) begin : g_bad_dw
      $error("hcube_router: DW must hold a DIM-bit destination");
   end

   logic [1:0]    kind_i  [NP];
   logic [DW-1:0] data_i  [NP];
   logic [IW-1:0] route_i [NP];
   logic [NP-1:0] req     [NP];
   logic          sel_ok  [NP];
   logic [IW-1:0] sel_idx [NP];
   logic [1:0]    okind   [NP];
   logic [NP-1:0] claim   [NP];

   for (genvar i = 0; i < NP; i++) begin : g_in
      assign kind_i[i] = in_kind[2*i +: 2];
      assign data_i[i] = in_data[DW*i +: DW];

      hcr_route #(.DIM(DIM), .NODE_ID(NODE_ID)) u_route (
         .dest (data_i[i][DIM-1:0]),
         .port (route_i[i])
      );
   end

   for (genvar o = 0; o < NP; o++) begin : g_out
      for (genvar i = 0; i < NP; i++) begin : g_req
         assign req[o][i] = in_valid[i] & kind_opens(kind_i[i]) & (route_i[i] == IW'(o));
      end

      assign okind[o]          = kind_i[sel_idx[o]];
      assign out_valid[o]      = sel_ok[o] & in_valid[sel_idx[o]];
      assign out_kind[2*o +: 2] = okind[o];
      assign out_data[DW*o +: DW] = data_i[sel_idx[o]];

      hcr_outsel #(.NP(NP)) u_sel (
         .clk     (clk),
         .rst_n   (rst_n),
         .req     (req[o]),
         .xfer    (out_valid[o] & out_ready[o]),
         .opens   (kind_opens(okind[o])),
         .closes  (kind_closes(okind[o])),
         .sel_ok  (sel_ok[o]),
         .sel_idx (sel_idx[o])
      );

      if (o < DIM) begin : g_link_chk
         localparam logic [DIM-1:0] LOW_MASK = DIM'((64'd1 << o) - 64'd1);
         logic [DIM-1:0] hx;
         assign hx = out_data[DW*o +: DIM] ^ NODE_ID;
         // R3: an opening flit on link o differs from the node at bit o and nowhere below
         p_link_route_r3: assert property (@(posedge clk) disable iff (!rst_n)
            (out_valid[o] && out_kind[2*o]) |-> (hx[o] && ((hx & LOW_MASK) == '0)));
      end else begin : g_eject_chk
         // R2: the local output carries only flits addressed to this node
         p_eject_dest_r2: assert property (@(posedge clk) disable iff (!rst_n)
            (out_valid[o] && out_kind[2*o]) |-> (out_data[DW*o +: DIM] == NODE_ID));
      end

      // R8: an output transfer is always matched by its source input transfer
      p_xfer_pair_r8: assert property (@(posedge clk) disable iff (!rst_n)
         (out_valid[o] && out_ready[o]) |-> (in_valid[sel_idx[o]] && in_ready[sel_idx[o]]));
   end

   // claim[i][o]: output o currently serves input i
   always_comb begin
      for (int i = 0; i < NP; i++) begin
         claim[i]    = '0;
         in_ready[i] = 1'b0;
         for (int o = 0; o < NP; o++) begin
            if (sel_ok[o] && sel_idx[o] == IW'(i)) begin
               claim[i][o] = 1'b1;
               if (out_ready[o]) in_ready[i] = 1'b1;
            end
         end
      end
   end

   for (genvar i = 0; i < NP; i++) begin : g_in_chk
      // R10: an input is served by at most one output at a time
      p_one_claim_r10: assert property (@(posedge clk) disable iff (!rst_n)
         $countones(claim[i]) <= 1);
   end
endmodule

// File: tb/hcube_router_tb.sv
`timescale 1ns/1ps
module hcube_router_tb;
   localparam int DIM = 3;
   localparam logic [DIM-1:0] NODE = 3'b010;
   localparam int DW = 8;
   localparam int NP = DIM + 1;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #2.5 clk = ~clk;

   logic [NP-1:0]    iv, ordy;
   logic [1:0]       ik [NP];
   logic [DW-1:0]    idat [NP];
   logic [2*NP-1:0]  in_kind_f;
   logic [DW*NP-1:0] in_data_f;
   logic [NP-1:0]    in_ready, out_valid;
   logic [2*NP-1:0]  out_kind;
   logic [DW*NP-1:0] out_data;

   always_comb begin
      for (int i = 0; i < NP; i++) begin
         in_kind_f[2*i +: 2]  = ik[i];
         in_data_f[DW*i +: DW] = idat[i];
      end
   end

   hcube_router #(.DIM(DIM), .NODE_ID(NODE), .DW(DW)) u_dut (
      .clk(clk), .rst_n(rst_n),
      .in_valid(iv), .in_ready(in_ready), .in_kind(in_kind_f), .in_data(in_data_f),
      .out_valid(out_valid), .out_ready(ordy), .out_kind(out_kind), .out_data(out_data)
   );

   int checks = 0;
   int errors = 0;
   int own [NP];

   function automatic int route(input logic [DW-1:0] d);
      logic [DIM-1:0] x;
      x = d[DIM-1:0] ^ NODE;
      for (int k = 0; k < DIM; k++) if (x[k]) return k;
      return DIM;
   endfunction

   task automatic put(input int p, input logic [1:0] k, input logic [DW-1:0] d);
      iv[p] = 1'b1; ik[p] = k; idat[p] = d;
   endtask

   task automatic idle_all();
      for (int p = 0; p < NP; p++) begin
         iv[p] = 1'b0; ik[p] = 2'b00; idat[p] = '0;
      end
   endtask

   // reference: expected outputs this cycle, then claim table update at the edge
   task automatic step(input string tag);
      int sel [NP];
      logic [NP-1:0] eov, eir;
      #1;
      eov = '0; eir = '0;
      for (int o = 0; o < NP; o++) begin
         sel[o] = -1;
         if (own[o] >= 0) sel[o] = own[o];
         else begin
            for (int i = 0; i < NP; i++)
               if (sel[o] < 0 && iv[i] && ik[i][0] && route(idat[i]) == o) sel[o] = i;
         end
         if (sel[o] >= 0) begin
            eov[o] = iv[sel[o]];
            if (ordy[o]) eir[sel[o]] = 1'b1;
         end
      end
      checks++;
      if (out_valid !== eov) begin
         errors++;
         $display("FAIL %s out_valid actual=%b expected=%b", tag, out_valid, eov);
      end
      checks++;
      if (in_ready !== eir) begin
         errors++;
         $display("FAIL %s in_ready actual=%b expected=%b", tag, in_ready, eir);
      end
      for (int o = 0; o < NP; o++) begin
         if (eov[o]) begin
            checks++;
            if (out_kind[2*o +: 2] !== ik[sel[o]] || out_data[DW*o +: DW] !== idat[sel[o]]) begin
               errors++;
               $display("FAIL %s port %0d flit actual=%b/%h expected=%b/%h", tag, o,
                        out_kind[2*o +: 2], out_data[DW*o +: DW], ik[sel[o]], idat[sel[o]]);
            end
         end
      end
      @(posedge clk);
      if (rst_n) begin
         for (int o = 0; o < NP; o++) begin
            if (eov[o] && ordy[o]) begin
               if (ik[sel[o]][1]) own[o] = -1;
               else if (ik[sel[o]][0]) own[o] = sel[o];
            end
         end
      end
      #1;
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      for (int o = 0; o < NP; o++) own[o] = -1;
      idle_all();
      ordy = '1;
      // R1: reset state
      step("R1");
      step("R1");
      rst_n = 1'b1;
      step("R1");

      // R2: addressed to this node -> local output
      put(3, 2'b11, 8'hA2); step("R2"); idle_all();
      // R3: lowest differing bit picks the link
      put(3, 2'b11, 8'h57); step("R3");
      put(3, 2'b11, 8'h36); step("R3");
      put(3, 2'b11, 8'h18); step("R3");
      put(3, 2'b11, 8'h03); step("R4"); idle_all();

      // R5/R6: path claimed by input 1, input 2 waits for it
      put(1, 2'b01, 8'h07); step("R5");
      put(1, 2'b00, 8'hC3); put(2, 2'b01, 8'h13); step("R6");
      put(1, 2'b00, 8'hC4); step("R6");
      put(1, 2'b10, 8'hC5); step("R5");
      iv[1] = 1'b0; step("R6");
      put(2, 2'b10, 8'hE1); step("R5"); idle_all();
      step("R5");

      // R7: lowest input wins a shared unclaimed output
      put(0, 2'b11, 8'h06); put(2, 2'b11, 8'h26); step("R7");
      iv[0] = 1'b0; step("R7"); idle_all();

      // R8: back-pressure holds flits and claim state
      ordy[0] = 1'b0; put(3, 2'b01, 8'h07); step("R8");
      ordy[0] = 1'b1; step("R8");
      put(3, 2'b00, 8'h99); ordy[0] = 1'b0; step("R8");
      put(2, 2'b11, 8'h17); step("R8"); iv[2] = 1'b0;
      ordy[0] = 1'b1; step("R8");
      put(3, 2'b10, 8'h9A); step("R8"); idle_all();

      // R10/R9: independent outputs in one cycle, payload intact
      put(3, 2'b11, 8'hF2); put(1, 2'b11, 8'h00); put(2, 2'b11, 8'h17); step("R10");
      put(0, 2'b11, 8'h5E); put(1, 2'b11, 8'hAB); step("R9"); idle_all();
      step("R1");

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule